// File: doc/BRIEF.md
# Multi-Mode Serial Baud Rate Generator

This block produces the bit-rate timing for a serial port that can run either as an asynchronous transceiver or as the clock master of a synchronous link. A free-running down-counter is loaded from a programmed divisor `n`. Each time it reaches zero it emits one oversample tick, so that tick comes every `n+1` clocks. A prescaler counts those oversample ticks and emits one baud tick for every 4, 16 or 64 of them. A receiver can use the oversample tick to place its samples. The shifter can use the baud tick to move one bit.

Three mode inputs set the behaviour. The wide input selects a 16-bit divisor; the default after reset is an 8-bit divisor. The fast input selects a shorter prescale in asynchronous operation. The sync input selects synchronous master operation, which always uses a prescale of 4. Any divisor write, or any change of a mode input, restarts both the counter and the prescaler at once. The first period after the change therefore already has its new length. In synchronous operation a divisor below 2 is not supported. The block flags such a divisor and runs as if the divisor were 2.

Top module: `baud_gen`

## Requirements
- R1: Synchronous active-low reset clears the divisor to 0 and all mode latches to 0 (8-bit width, fast off, asynchronous). While reset is low, `baud_tick`, `os_tick` and `sync_err` are 0.
- R2: Asynchronous operation with wide=0 and fast=0 gives one baud tick every 64·(n+1) clocks.
- R3: Asynchronous operation with wide=0 and fast=1, or with wide=1 and fast=0, gives one baud tick every 16·(n+1) clocks.
- R4: Asynchronous operation with wide=1 and fast=1 gives one baud tick every 4·(n+1) clocks.
- R5: Synchronous operation (sync=1) gives one baud tick every 4·(n+1) clocks at either width. The fast input has no effect on the period.
- R6: With wide=0 only bits [7:0] of the divisor are used, and bits [15:8] count as zero.
- R7: A write (`div_we` high at a clock edge) stores `div_wdata` and restarts at that edge. Counting t=0 as the first cycle after the edge, `os_tick` is high when t mod (n+1) = n. `baud_tick` is high when t mod (P·(n+1)) = P·(n+1)−1, where P is the prescale.
- R8: A change of any mode input, compared with the value latched at the previous edge, latches the new modes and restarts the count with the same timing as R7.
- R9: An asynchronous divisor of 0 makes `os_tick` high on every cycle and gives a baud tick every P cycles, with no stall.
- R10: `sync_err` is 1 exactly when the latched mode is synchronous and the effective divisor (after R6 masking) is below 2. In that case the timing uses a divisor of 2.
- R11: Every baud tick is one clock wide and coincides with an oversample tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 16 | Divisor value to write |
| mode_fast | input | 1 | Shorter asynchronous prescale |
| mode_wide | input | 1 | 16-bit divisor enable |
| mode_sync | input | 1 | Synchronous master operation |
| baud_tick | output | 1 | One-cycle bit-rate tick |
| os_tick | output | 1 | One-cycle oversample tick, every n+1 clocks |
| sync_err | output | 1 | Unsupported synchronous divisor in use |

## Verification
The bench applies all four asynchronous combinations of width and fast bits, plus synchronous operation with the fast bit toggled. It compares both ticks on every cycle, so an incorrect prescale shows up as a wrong period. A divisor with nonzero high byte is written in 8-bit mode, which separates correct masking from use of the full word. Writes and mode changes placed in the middle of a period separate an immediate restart from a reload at the next expiry. Divisors 0, 1 and a masked zero in synchronous mode exercise the error flag and the clamp to 2, and divisor 0 in asynchronous mode shows the counter neither stalls nor wraps.

// File: rtl/baud_pkg.sv
// Shared constants and helpers for the baud rate generator.
// Assumes prescale values 4, 16 and 64 fit in PRE_W bits as a terminal count.
package baud_pkg;
    localparam int PRE_W = 6;

    // Terminal prescaler count (prescale minus one) for a mode combination.
    function automatic logic [PRE_W-1:0] pre_last(input logic fast, input logic wide,
                                                  input logic sync);
        if (sync || (wide && fast)) return PRE_W'(3);
        else if (wide ^ fast)       return PRE_W'(15);
        else                        return PRE_W'(63);
    endfunction
endpackage

// File: rtl/baud_cfg.sv
// Combinational decode of divisor and mode bits into the effective reload value,
// prescaler terminal count and synchronous error flag.
// Assumes LOW_W < DIV_W; narrow mode masks the divisor to LOW_W bits.
module baud_cfg #(
    parameter int DIV_W = 16,
    parameter int LOW_W = 8
) (
    input  logic [DIV_W-1:0]          div,
    input  logic                      fast,
    input  logic                      wide,
    input  logic                      sync,
    output logic [DIV_W-1:0]          reload,
    output logic [baud_pkg::PRE_W-1:0] pre_last,
    output logic                      err
);
    localparam logic [DIV_W-1:0] LOW_MASK = {{(DIV_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};
    localparam logic [DIV_W-1:0] SYNC_MIN = DIV_W'(2);

    logic [DIV_W-1:0] masked;

    // Mask, clamp and prescale selection.
    always_comb begin
        masked   = wide ? div : (div & LOW_MASK);
        err      = sync && (masked < SYNC_MIN);
        reload   = err ? SYNC_MIN : masked;
        pre_last = baud_pkg::pre_last(fast, wide, sync);
    end
endmodule

// File: rtl/baud_counter.sv
// Free-running down-counter: loads on restart, reloads on reaching zero.
// Assumes reload values come from baud_cfg; zero is signalled on expire.
module baud_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] load_new,
    input  logic [DIV_W-1:0] load_run,
    output logic             expire
);
    logic [DIV_W-1:0] cnt;

    assign expire = (cnt == '0);

    // Count down, restart immediately, or reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (restart)  cnt <= load_new;
        else if (expire)   cnt <= load_run;
        else               cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/baud_prescaler.sv
// Counts oversample ticks and flags the last one of each prescale group.
// Assumes pre_last is stable except across a restart.
module baud_prescaler #(
    parameter int PRE_W = baud_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [PRE_W-1:0] pre_last,
    output logic             at_last
);
    logic [PRE_W-1:0] pre;

    assign at_last = (pre == pre_last);

    // Advance on each oversample tick, wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre <= '0;
        else if (restart) pre <= '0;
        else if (step)    pre <= at_last ? '0 : pre + 1'b1;
    end
endmodule

// File: rtl/baud_gen.sv
// Top of the multi-mode baud rate generator. Latches divisor and modes,
// restarts on any write or mode change, and emits oversample and baud ticks.
// Assumes mode inputs are synchronous to clk.
module baud_gen #(
    parameter int DIV_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             mode_fast,
    input  logic             mode_wide,
    input  logic             mode_sync,
    output logic             baud_tick,
    output logic             os_tick,
    output logic             sync_err
);
    localparam int PRE_W = baud_pkg::PRE_W;

    logic [DIV_W-1:0] div_q, div_nxt, reload_cur, reload_nxt;
    logic [PRE_W-1:0] last_cur, last_nxt;
    logic             fast_q, wide_q, sync_q;
    logic             err_cur, err_nxt, restart, expire, at_last;

    assign div_nxt = div_we ? div_wdata : div_q;
    assign restart = div_we || ({mode_fast, mode_wide, mode_sync} != {fast_q, wide_q, sync_q});

    // Latch divisor and mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            fast_q <= 1'b0;
            wide_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            div_q  <= div_nxt;
            fast_q <= mode_fast;
            wide_q <= mode_wide;
            sync_q <= mode_sync;
        end
    end

    baud_cfg #(.DIV_W(DIV_W), .LOW_W(LOW_W)) i_cfg_cur (
        .div(div_q), .fast(fast_q), .wide(wide_q), .sync(sync_q),
        .reload(reload_cur), .pre_last(last_cur), .err(err_cur)
    );

    baud_cfg #(.DIV_W(DIV_W), .LOW_W(LOW_W)) i_cfg_nxt (
        .div(div_nxt), .fast(mode_fast), .wide(mode_wide), .sync(mode_sync),
        .reload(reload_nxt), .pre_last(last_nxt), .err(err_nxt)
    );

    baud_counter #(.DIV_W(DIV_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .load_new(reload_nxt), .load_run(reload_cur), .expire(expire)
    );

    baud_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .step(expire), .pre_last(last_cur), .at_last(at_last)
    );

    logic unused_nxt;
    assign unused_nxt = err_nxt ^ (^last_nxt);

    assign os_tick   = rst_n && expire;
    assign baud_tick = rst_n && expire && at_last;
    assign sync_err  = rst_n && err_cur;
endmodule

// File: rtl/baud_gen_checker.sv
// Checker for baud_gen: tick shape, restart behaviour and error flag scope.
module baud_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic div_we,
    input logic mode_sync,
    input logic baud_tick,
    input logic os_tick,
    input logic sync_err
);
    // R11: baud tick lasts one cycle.
    a_r11_baud_single: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    // R11: baud tick coincides with an oversample tick.
    a_r11_baud_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> os_tick);

    // R7: a write restarts the prescaler, so no baud tick follows at once.
    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |=> !baud_tick);

    // R10: error flag only while synchronous mode is latched.
    a_r10_err_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sync |=> !sync_err);
endmodule

bind baud_gen baud_gen_checker i_chk (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .mode_sync(mode_sync),
    .baud_tick(baud_tick), .os_tick(os_tick), .sync_err(sync_err)
);

// File: tb/test_baud_gen.sv
module test_baud_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_we = 1'b0;
    logic [15:0] div_wdata = '0;
    logic        mode_fast = 1'b0, mode_wide = 1'b0, mode_sync = 1'b0;
    logic        baud_tick, os_tick, sync_err;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    // Behavioural model state.
    int          t = 0;
    logic [15:0] m_div = '0;
    logic        m_fast = 1'b0, m_wide = 1'b0, m_sync = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_gen i_baud_gen (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
        .mode_fast(mode_fast), .mode_wide(mode_wide), .mode_sync(mode_sync),
        .baud_tick(baud_tick), .os_tick(os_tick), .sync_err(sync_err)
    );

    // Model: time since last restart and latched settings.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            t = 0; m_div = '0; m_fast = 0; m_wide = 0; m_sync = 0;
        end else if (div_we || mode_fast != m_fast || mode_wide != m_wide || mode_sync != m_sync) begin
            if (div_we) m_div = div_wdata;
            m_fast = mode_fast; m_wide = mode_wide; m_sync = mode_sync;
            t = 0;
        end else begin
            t = t + 1;
        end
    end

    task automatic compare(input string req);
        int raw, eff, p, per;
        logic e_os, e_baud, e_err;
        raw = m_wide ? int'(m_div) : int'(m_div[7:0]);
        e_err = m_sync && raw < 2;
        eff = e_err ? 2 : raw;
        if (m_sync || (m_wide && m_fast)) p = 4;
        else if (m_wide != m_fast)        p = 16;
        else                              p = 64;
        per = p * (eff + 1);
        e_os   = rst_n && (t % (eff + 1) == eff);
        e_baud = rst_n && (t % per == per - 1);
        if (!rst_n) e_err = 1'b0;
        vectors = vectors + 1;
        if ({baud_tick, os_tick, sync_err} !== {e_baud, e_os, e_err}) begin
            miscompares = miscompares + 1;
            $display("FAIL %s t=%0d: baud/os/err actual %b%b%b expected %b%b%b",
                     req, t, baud_tick, os_tick, sync_err, e_baud, e_os, e_err);
        end
    endtask

    task automatic run(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare(req);
            div_we = 1'b0;
        end
    endtask

    task automatic wr(input logic [15:0] v);
        div_we = 1'b1;
        div_wdata = v;
    endtask

    task automatic modes(input logic f, input logic w, input logic s);
        mode_fast = f; mode_wide = w; mode_sync = s;
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        miscompares = miscompares + 1;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        run("R1", 4);
        rst_n = 1'b1;
        run("R9", 200);                // divisor 0, 8-bit, prescale 64
        wr(16'd3);   run("R2", 800);   // period 256
        modes(1, 0, 0); run("R8", 300);
        wr(16'd5);   run("R3", 300);   // period 96
        modes(0, 1, 0); wr(16'h0102); run("R3", 9000); // period 4144
        modes(1, 0, 0); wr(16'h0A03); run("R6", 300);  // masked to 3
        modes(1, 1, 0); wr(16'd0); run("R9", 50);      // every 4
        wr(16'd7);   run("R4", 200);
        wr(16'd20);  run("R7", 30);
        wr(16'd9);   run("R7", 100);
        modes(0, 1, 0); run("R8", 25);
        modes(1, 1, 0); run("R8", 200);
        modes(0, 0, 1); wr(16'd5); run("R5", 100);
        mode_fast = 1'b1; run("R5", 100);
        modes(1, 1, 1); run("R5", 100);
        wr(16'd0);   run("R10", 60);
        wr(16'd1);   run("R10", 60);
        modes(0, 0, 1); wr(16'h0100); run("R10", 60);
        modes(0, 0, 0); run("R10", 300);
        modes(1, 1, 0); wr(16'd2); run("R11", 100);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule